// File: doc/BRIEF.md
# Periodic Serial Status Line Transmitter

This block sends a one-line text report over an asynchronous serial line each time the frequency-control loop finishes an update. On the update strobe it takes a snapshot of three quantities: the accumulated phase count, the upper sixteen bits of the 18-bit control DAC word, and a status code made from the loop mode and two alarm flags. Each quantity is turned into five decimal digits, and the resulting line of text leaves the TX pin as 8N1 characters.

The three numbers are zero-padded to five digits and separated by single spaces. The line ends with carriage return and line feed. A sequential shift-and-add-3 converter produces the digits before the first character starts. A clock divider with a parameter sets the bit time, so the serial rate follows from the system clock. When the strobe arrives while a line is still being sent, the block ignores it.

Top module: `status_line_tx`

## Requirements
- R1: While reset is held and whenever no report is in progress, `tx` is high (idle), and no character is sent unless a strobe is accepted.
- R2: Every character is framed as one low start bit, then 8 data bits with the LSB first, then one high stop bit. Each bit lasts `CLKS_PER_BIT` clock cycles.
- R3: An accepted strobe produces exactly 19 characters, in this order: five digits of field 1, a space (0x20), five digits of field 2, a space, five digits of field 3, CR (0x0D), LF (0x0A). A digit d is sent as ASCII 0x30+d. The most significant digit comes first, with leading zeros.
- R4: Field 1 is `phase_cnt` printed as an unsigned decimal number (0 to 65535).
- R5: Field 2 is `dac_word[17:2]` printed as an unsigned decimal number. For example, `dac_word` = 0x3FFFF prints 65535 and 0x20003 prints 32768.
- R6: Field 3 is `mode` + 10 when `glitch_flag` is set + 100 when `unlock_flag` is set. For example, mode 5 with unlock prints 00105, and mode 7 with both flags prints 00117.
- R7: All inputs are captured in the cycle the strobe is accepted. Input changes after that cycle do not alter the report.
- R8: A strobe that arrives while a report is being converted or sent, up to the end of the LF stop bit, is ignored. It produces no extra characters and does not disturb the line in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | Loop update strobe, one cycle |
| phase_cnt | input | 16 | Accumulated phase count |
| dac_word | input | 18 | Control DAC word; upper 16 bits are reported |
| mode | input | 3 | Loop filter mode, 0 to 7 |
| glitch_flag | input | 1 | A spurious phase sample was rejected |
| unlock_flag | input | 1 | Lock is doubtful |
| tx | output | 1 | Serial transmit line, idle high |

## Verification
A corrupted digit register or converter step shows up as a wrong ASCII character in the same line. The first bad character appears at most one frame after the digit's position is reached. A wrong character index or state shows up within one line: characters are missing or extra, or the CR/LF falls in the wrong place. A strobe that is not blocked while the block is busy shows up as a whole unexpected line after the current one ends. A wrong divider count changes the bit width, which shows up in the length of the first low run of a line.

// File: rtl/sltx_pkg.sv
package sltx_pkg;

    localparam int FIELD_W  = 16;
    localparam int DIGITS   = 5;
    localparam int NFIELDS  = 3;
    localparam int BCD_W    = DIGITS * 4;
    localparam int LINE_LEN = NFIELDS * (DIGITS + 1) + 1;
    localparam int IDX_W    = $clog2(LINE_LEN);

    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [3:0] CH_DIGIT_HI = 4'h3;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [BCD_W-1:0]   bcd_t;
    typedef logic [IDX_W-1:0]   cidx_t;

    typedef struct packed {
        field_t phase;
        field_t dac;
        field_t status;
    } report_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV_GO,
        ST_CONV_WAIT,
        ST_SEND
    } seq_state_t;

    function automatic field_t status_code(logic [2:0] md, logic glitch, logic unlock);
        field_t v;
        v = field_t'(md);
        if (glitch) v = v + field_t'(10);
        if (unlock) v = v + field_t'(100);
        return v;
    endfunction

    function automatic logic [7:0] line_char(cidx_t idx, logic [NFIELDS-1:0][BCD_W-1:0] dig);
        int         f;
        int         p;
        logic [3:0] nib;
        logic [7:0] ch;
        if (int'(idx) == LINE_LEN - 2) begin
            ch = CH_CR;
        end else if (int'(idx) == LINE_LEN - 1) begin
            ch = CH_LF;
        end else begin
            f = int'(idx) / (DIGITS + 1);
            p = int'(idx) - f * (DIGITS + 1);
            if (p == DIGITS) begin
                ch = CH_SPACE;
            end else begin
                nib = 4'(dig[f[1:0]] >> (4 * (DIGITS - 1 - p)));
                ch  = {CH_DIGIT_HI, nib};
            end
        end
        return ch;
    endfunction

endpackage

// File: rtl/sltx_baud.sv
module sltx_baud #(
    parameter int DIV = 20833
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    // R2: the bit counter never leaves its range
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < DIV);

    generate
        if (DIV > 1) begin : g_spacing
            // R2: two ticks are never adjacent
            p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/sltx_bcd_conv.sv
module sltx_bcd_conv #(
    parameter int W = 16,
    parameter int D = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   bin,
    output logic           busy,
    output logic           done,
    output logic [4*D-1:0] bcd
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]     sh_bin;
    logic [4*D-1:0]   sh_bcd;
    logic [4*D-1:0]   adj;
    logic [CNT_W-1:0] step;
    logic [4*D+W-1:0] shifted;

    generate
        for (genvar k = 0; k < D; k++) begin : g_adj
            logic [3:0] nib;
            assign nib = sh_bcd[4*k +: 4];
            assign adj[4*k +: 4] = (nib >= 4'd5) ? nib + 4'd3 : nib;
        end
    endgenerate

    assign shifted = {adj, sh_bin} << 1;
    assign bcd     = sh_bcd;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_bin <= '0;
            sh_bcd <= '0;
            step   <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    sh_bin <= bin;
                    sh_bcd <= '0;
                    step   <= '0;
                    busy   <= 1'b1;
                end
            end else begin
                {sh_bcd, sh_bin} <= shifted;
                step <= step + 1'b1;
                if (step == CNT_W'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    generate
        for (genvar k = 0; k < D; k++) begin : g_chk
            // R3: every finished digit is a decimal digit
            p_digit_range_r3: assert property (@(posedge clk) disable iff (rst)
                done |-> (bcd[4*k +: 4] <= 4'd9));
        end
    endgenerate

    // R3: a result is only flagged after a conversion was running
    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

endmodule

// File: rtl/sltx_uart_tx.sv
module sltx_uart_tx #(
    parameter int DIV = 20833
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] data,
    output logic       tx,
    output logic       busy
);
    logic [9:0] frame;
    logic [3:0] bitn;
    logic       tick;

    sltx_baud #(.DIV(DIV)) i_baud (
        .clk (clk),
        .rst (rst),
        .en  (busy),
        .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '1;
            bitn  <= '0;
            busy  <= 1'b0;
        end else if (!busy) begin
            if (load) begin
                frame <= {1'b1, data, 1'b0};
                bitn  <= '0;
                busy  <= 1'b1;
            end
        end else if (tick) begin
            frame <= {1'b1, frame[9:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == 4'd9) busy <= 1'b0;
        end
    end

    assign tx = busy ? frame[0] : 1'b1;

    // R1: the line rests high between frames
    p_idle_line_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);
    // R2: each frame opens with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx);
    // R2: the last bit before going idle is the high stop bit
    p_stop_high_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tx));

endmodule

// File: rtl/status_line_tx.sv
module status_line_tx
    import sltx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 20833
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        upd_stb,
    input  logic [15:0] phase_cnt,
    input  logic [17:0] dac_word,
    input  logic [2:0]  mode,
    input  logic        glitch_flag,
    input  logic        unlock_flag,
    output logic        tx
);
    seq_state_t                    state;
    report_t                       rep;
    logic [1:0]                    fsel;
    logic [NFIELDS-1:0][BCD_W-1:0] dig;
    cidx_t                         cidx;

    logic   accept;
    logic   conv_start, conv_busy, conv_done;
    bcd_t   conv_bcd;
    field_t conv_in;
    logic   tx_load, tx_busy;
    logic [7:0] tx_data;

    assign accept     = (state == ST_IDLE) && !tx_busy && upd_stb;
    assign conv_start = (state == ST_CONV_GO);
    assign tx_load    = (state == ST_SEND) && !tx_busy;
    assign tx_data    = line_char(cidx, dig);

    always_comb begin
        case (fsel)
            2'd0:    conv_in = rep.phase;
            2'd1:    conv_in = rep.dac;
            default: conv_in = rep.status;
        endcase
    end

    sltx_bcd_conv #(.W(FIELD_W), .D(DIGITS)) i_conv (
        .clk  (clk),
        .rst  (rst),
        .start(conv_start),
        .bin  (conv_in),
        .busy (conv_busy),
        .done (conv_done),
        .bcd  (conv_bcd)
    );

    sltx_uart_tx #(.DIV(CLKS_PER_BIT)) i_uart (
        .clk (clk),
        .rst (rst),
        .load(tx_load),
        .data(tx_data),
        .tx  (tx),
        .busy(tx_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            rep   <= '0;
            fsel  <= '0;
            dig   <= '0;
            cidx  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        rep.phase  <= phase_cnt;
                        rep.dac    <= dac_word[17:2];
                        rep.status <= status_code(mode, glitch_flag, unlock_flag);
                        fsel       <= '0;
                        state      <= ST_CONV_GO;
                    end
                end
                ST_CONV_GO: begin
                    state <= ST_CONV_WAIT;
                end
                ST_CONV_WAIT: begin
                    if (conv_done) begin
                        dig[fsel] <= conv_bcd;
                        if (int'(fsel) == NFIELDS - 1) begin
                            cidx  <= '0;
                            state <= ST_SEND;
                        end else begin
                            fsel  <= fsel + 1'b1;
                            state <= ST_CONV_GO;
                        end
                    end
                end
                ST_SEND: begin
                    if (tx_load) begin
                        if (int'(cidx) == LINE_LEN - 1) state <= ST_IDLE;
                        else                            cidx  <= cidx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: the captured fields hold still while a report is under way
    p_hold_fields_r7: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(rep));
    // R8: a strobe during a report or its last frame leaves the snapshot alone
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && ((state != ST_IDLE) || tx_busy)) |=> $stable(rep));
    // R6: the status code cannot exceed 7 + 10 + 100
    p_status_max_r6: assert property (@(posedge clk) disable iff (rst)
        rep.status <= field_t'(117));
    // R3: the character index stays inside the line
    p_index_bound_r3: assert property (@(posedge clk) disable iff (rst)
        int'(cidx) < LINE_LEN);
    // R3: the converter is never started while it is still running
    p_conv_start_idle_r3: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !conv_busy);

endmodule

// File: tb/test_status_line_tx.sv
`timescale 1ns/1ps
module test_status_line_tx;

    localparam int DIV = 16;
    localparam int LINE = 19;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_stb = 1'b0;
    logic [15:0] phase_in = '0;
    logic [17:0] dac_in = '0;
    logic [2:0]  mode_in = '0;
    logic        glitch_in = 1'b0;
    logic        unlock_in = 1'b0;
    logic        tx;

    int   checks = 0;
    int   errors = 0;
    int   rx_bytes = 0;
    int   pos = 0;
    byte  exp_q[$];

    always #2.5 clk = ~clk;

    status_line_tx #(.CLKS_PER_BIT(DIV)) i_status_line_tx (
        .clk        (clk),
        .rst        (rst),
        .upd_stb    (upd_stb),
        .phase_cnt  (phase_in),
        .dac_word   (dac_in),
        .mode       (mode_in),
        .glitch_flag(glitch_in),
        .unlock_flag(unlock_in),
        .tx         (tx)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_line(input int a, input int b, input int c);
        string s;
        s = $sformatf("%05d %05d %05d", a, b, c);
        for (int i = 0; i < s.len(); i++) exp_q.push_back(byte'(s[i]));
        exp_q.push_back(8'h0D);
        exp_q.push_back(8'h0A);
    endtask

    task automatic fire(input int ph, input int dac, input int md, input bit g, input bit u);
        @(negedge clk);
        phase_in  = 16'(ph);
        dac_in    = 18'(dac);
        mode_in   = 3'(md);
        glitch_in = g;
        unlock_in = u;
        upd_stb   = 1'b1;
        @(negedge clk);
        upd_stb   = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (2 * DIV) @(posedge clk);
    endtask

    task automatic report(input int ph, input int dac, input int md, input bit g, input bit u);
        push_line(ph, dac >> 2, md + (g ? 10 : 0) + (u ? 100 : 0));
        fire(ph, dac, md, g, u);
        drain();
    endtask

    // monitor: serial receiver and scoreboard
    initial begin
        forever begin
            logic [7:0] d;
            byte        e;
            string      tag;
            @(negedge tx);
            if (rst) continue;
            repeat (DIV / 2) @(posedge clk);
            #1;
            chk(tx == 1'b0, "R2 start bit", int'(tx), 0);
            for (int b = 0; b < 8; b++) begin
                repeat (DIV) @(posedge clk);
                #1;
                d[b] = tx;
            end
            repeat (DIV) @(posedge clk);
            #1;
            chk(tx == 1'b1, "R2 stop bit", int'(tx), 1);
            rx_bytes++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected character", int'(d), -1);
            end else begin
                e = exp_q.pop_front();
                if (pos < 5)                 tag = "R4 phase digit";
                else if (pos > 5 && pos < 11) tag = "R5 dac digit";
                else if (pos > 11 && pos < 17) tag = "R6 status digit";
                else                          tag = "R3 separator";
                chk(d == 8'(e), tag, int'(d), int'(e));
                pos = (pos + 1) % LINE;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(posedge clk);
        #1;
        chk(tx == 1'b1, "R1 tx high in reset", int'(tx), 1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(tx == 1'b1, "R1 tx high after reset", int'(tx), 1);
        repeat (500) @(posedge clk);
        #1;
        chk(rx_bytes == 0, "R1 silent without strobe", rx_bytes, 0);

        // R4 R5 R6: typical locked report, negative DAC, doubtful lock
        report(800, 18'h3FFFF, 5, 1'b0, 1'b1);

        // R2: all-zero line; first char '0' = 0x30 -> start + 4 zero bits low = 5 bit times
        push_line(0, 0, 0);
        fork
            begin
                @(negedge tx);
                n = 0;
                do begin
                    @(posedge clk);
                    #1;
                    n++;
                end while (tx == 1'b0);
                chk(n == 5 * DIV, "R2 bit time", n, 5 * DIV);
            end
            fire(0, 0, 0, 1'b0, 1'b0);
        join
        drain();

        // R4 R5 R6: extremes, DAC midpoint, both flags
        report(65535, 18'h20003, 7, 1'b1, 1'b1);
        report(12345, 18'h0C0DE, 3, 1'b1, 1'b0);

        // R7: inputs change right after the strobe
        push_line(4321, 1000, 2);
        fire(4321, 4000, 2, 1'b0, 1'b0);
        phase_in  = 16'd9999;
        dac_in    = 18'h3FFFF;
        mode_in   = 3'd7;
        glitch_in = 1'b1;
        unlock_in = 1'b1;
        drain();

        // R8: strobe during the line and during the final LF frame
        n = rx_bytes;
        push_line(111, 222, 6);
        fire(111, 888, 6, 1'b0, 1'b0);
        repeat (600) @(posedge clk);
        fire(55555, 0, 1, 1'b1, 1'b1);
        while (exp_q.size() > 1) @(posedge clk);
        repeat (3 * DIV) @(posedge clk);
        fire(22222, 4, 4, 1'b0, 1'b1);
        drain();
        repeat (LINE * 12 * DIV) @(posedge clk);
        chk(rx_bytes - n == LINE, "R8 one line only", rx_bytes - n, LINE);

        // R8: a strobe after the line has finished is taken again
        report(2, 8, 1, 1'b1, 1'b0);

        chk(exp_q.size() == 0, "R3 all characters received", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule